// File: doc/BRIEF.md
# MSI Snooping Coherence Controller

This block keeps one cache's copy of a small direct-mapped set of lines coherent with the other caches on a shared snooping bus. Each line is Invalid, Shared (a clean, read-only copy) or Modified (the only valid copy, dirty and writable). The processor side presents load, store and evict requests for a line address. Requests that can finish on the local state complete at once. The others raise a bus request, hold the processor stalled until the bus grants and the transaction ends, and then update the line.

At the same time the controller watches every transaction that other caches put on the bus. When it owns a line in Modified state and another cache reads it, the controller answers with its own reply strobe, which memory also watches to take the dirty data, and keeps only a Shared copy. Requests for exclusive access and dataless upgrades from other caches invalidate the local copy. A store to a Shared line upgrades with a dataless invalidate and does not wait for a data reply. Data storage, replacement choice and bus arbitration beyond a request and grant pair lie outside the block.

Top module: `msi_snoop_ctrl`

## Requirements
- R1: After reset every line is Invalid, and no bus request, processor completion or snoop reply is raised while no request or snoop is presented.
- R2: A load (request code 0) to an Invalid line raises the bus request and, in the granted cycle, issues command code 1 (shared read). It stalls until the reply strobe, completes in the cycle of that strobe, and leaves the line Shared.
- R3: A store (request code 1) to an Invalid line issues command code 2 (exclusive read) when granted, completes in the cycle of the reply strobe and leaves the line Modified.
- R4: A store to a Shared line issues command code 3 (dataless invalidate) when granted, completes in that same granted cycle without waiting for a reply, and leaves the line Modified.
- R5: An evict (request code 2) of a Shared line completes at once with no bus request and leaves the line Invalid. An evict of a Modified line issues command code 4 (write-back) when granted, completes in that cycle and leaves the line Invalid.
- R6: A load to a Shared or Modified line, a store to a Modified line and an evict of an Invalid line each complete in the cycle the request is presented, with no bus request and no change of line state.
- R7: A snooped shared read (code 1) from another cache that hits a Modified line raises the snoop reply in that same cycle and leaves the line Shared.
- R8: A snooped exclusive read (code 2) that hits a Modified line raises the snoop reply and invalidates the line. A snooped exclusive read or invalidate (code 3) that hits a Shared line invalidates it without a reply. A snooped write-back (code 4) changes nothing.
- R9: A snooped transaction whose source id equals the controller's own id changes no line and raises no reply.
- R10: Snoops are serviced while a request waits for its grant, and the bus command is chosen from the line state in the granted cycle. A store waiting to upgrade a line that a snoop has invalidated issues an exclusive read instead, and an evict waiting on a line that a snoop has downgraded to Shared completes without the bus.
- R11: A line whose stored tag differs from the address tag counts as Invalid for that address. An evict of such an address leaves the resident line untouched.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Processor request present |
| req_op | input | 2 | 0 load, 1 store, 2 evict |
| req_addr | input | ADDR_W | Line address of the request |
| req_done | output | 1 | Request completes in this cycle |
| req_stall | output | 1 | Request present and not yet complete |
| bus_req | output | 1 | Asks the arbiter for the bus |
| bus_gnt | input | 1 | Bus granted in this cycle |
| bus_cmd | output | 3 | Command issued in the granted cycle (0 idle) |
| bus_addr | output | ADDR_W | Address of the issued command |
| bus_reply_in | input | 1 | Data reply for this controller's read |
| snp_cmd | input | 3 | Command seen on the bus (0 idle) |
| snp_addr | input | ADDR_W | Address of the snooped command |
| snp_id | input | ID_W | Source id of the snooped command |
| snp_reply | output | 1 | This cache supplies the snooped line's data |

## Verification
The assertions assume the processor holds its request and address unchanged while stalled, that the reply strobe comes only while a read of this controller is outstanding, and that no other cache's command shares a cycle with the reply. The bench keeps to this by acting as arbiter and memory itself: it grants only a raised request, answers a read one cycle after it appears, and presents snoops only while the controller is idle or waiting for its grant. It walks every start state against every processor request and every snoop command from both its own and another id, and reads back each resulting line state through snoops and processor requests at the ports.

// File: rtl/msi_pkg.sv
// Shared encodings for the MSI snooping controller.
// Assumes: command codes match those used by every agent on the bus.
package msi_pkg;
    typedef enum logic [1:0] {
        LS_INV = 2'd0,
        LS_SHD = 2'd1,
        LS_MOD = 2'd2
    } line_st_t;

    typedef enum logic [1:0] {
        OP_LOAD  = 2'd0,
        OP_STORE = 2'd1,
        OP_EVICT = 2'd2
    } proc_op_t;

    typedef enum logic [2:0] {
        BC_IDLE = 3'd0,
        BC_RD   = 3'd1,
        BC_RDX  = 3'd2,
        BC_INV  = 3'd3,
        BC_WB   = 3'd4
    } bus_cmd_t;
endpackage

// File: rtl/msi_line_array.sv
// Direct-mapped store of line state and tag with two read ports and two
// write ports. The processor-side write wins over a snoop write on the
// same index in the same cycle.
// Assumes: write indices are in range; reset clears every line to Invalid.
module msi_line_array
    import msi_pkg::*;
#(
    parameter int IDX_W = 2,
    parameter int TAG_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rda_idx,
    output line_st_t         rda_st,
    output logic [TAG_W-1:0] rda_tag,
    input  logic [IDX_W-1:0] rdb_idx,
    output line_st_t         rdb_st,
    output logic [TAG_W-1:0] rdb_tag,
    input  logic             own_we,
    input  logic [IDX_W-1:0] own_idx,
    input  logic [TAG_W-1:0] own_tag,
    input  line_st_t         own_st,
    input  logic             snp_we,
    input  logic [IDX_W-1:0] snp_idx,
    input  line_st_t         snp_st
);
    localparam int LINES = 1 << IDX_W;

    line_st_t         st_q  [LINES];
    logic [TAG_W-1:0] tag_q [LINES];

    generate
        for (genvar g = 0; g < LINES; g++) begin : g_line
            // Update one line: reset, processor write, else snoop write.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    st_q[g]  <= LS_INV;
                    tag_q[g] <= '0;
                end else if (own_we && (own_idx == IDX_W'(g))) begin
                    st_q[g]  <= own_st;
                    tag_q[g] <= own_tag;
                end else if (snp_we && (snp_idx == IDX_W'(g))) begin
                    st_q[g]  <= snp_st;
                end
            end
        end
    endgenerate

    // Read both ports.
    always_comb begin
        rda_st  = st_q[rda_idx];
        rda_tag = tag_q[rda_idx];
        rdb_st  = st_q[rdb_idx];
        rdb_tag = tag_q[rdb_idx];
    end
endmodule

// File: rtl/msi_snoop_unit.sv
// Decides the local reaction to one snooped bus command: the new line
// state, whether to write it, and whether to supply data.
// Assumes: cur_st is already Invalid when the stored tag does not match.
module msi_snoop_unit
    import msi_pkg::*;
#(
    parameter int ID_W  = 2,
    parameter int MY_ID = 0
) (
    input  logic [2:0]      snp_cmd,
    input  logic [ID_W-1:0] snp_id,
    input  line_st_t        cur_st,
    output logic            upd_we,
    output line_st_t        upd_st,
    output logic            reply
);
    logic foreign;

    // Map the snooped command and local state to an action.
    always_comb begin
        foreign = (snp_id != ID_W'(MY_ID));
        upd_we  = 1'b0;
        upd_st  = cur_st;
        reply   = 1'b0;
        if (foreign) begin
            unique case (bus_cmd_t'(snp_cmd))
                BC_RD: begin
                    if (cur_st == LS_MOD) begin
                        reply  = 1'b1;
                        upd_we = 1'b1;
                        upd_st = LS_SHD;
                    end
                end
                BC_RDX: begin
                    if (cur_st != LS_INV) begin
                        reply  = (cur_st == LS_MOD);
                        upd_we = 1'b1;
                        upd_st = LS_INV;
                    end
                end
                BC_INV: begin
                    if (cur_st == LS_SHD) begin
                        upd_we = 1'b1;
                        upd_st = LS_INV;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/msi_req_fsm.sv
// Processor-side sequencer. Chooses the bus command from the current line
// state every cycle, requests the bus, issues the command in the granted
// cycle and waits for a data reply after reads.
// Assumes: the request stays unchanged until req_done; the reply strobe
// arrives only while a read is outstanding.
module msi_req_fsm
    import msi_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     req_valid,
    input  logic [1:0] req_op,
    input  line_st_t cur_st,
    input  logic     bus_gnt,
    input  logic     bus_reply_in,
    output logic     req_done,
    output logic     bus_req,
    output bus_cmd_t cmd,
    output logic     own_we,
    output line_st_t own_st
);
    typedef enum logic {PH_ARB = 1'b0, PH_WAIT = 1'b1} phase_t;

    phase_t   ph_q, ph_d;
    bus_cmd_t need;
    proc_op_t op;

    // Bus command the request would need with the current line state.
    always_comb begin
        op   = proc_op_t'(req_op);
        need = BC_IDLE;
        unique case (op)
            OP_LOAD:  need = (cur_st == LS_INV) ? BC_RD : BC_IDLE;
            OP_STORE: need = (cur_st == LS_INV) ? BC_RDX :
                             (cur_st == LS_SHD) ? BC_INV : BC_IDLE;
            OP_EVICT: need = (cur_st == LS_MOD) ? BC_WB : BC_IDLE;
            default:  need = BC_IDLE;
        endcase
    end

    // Outputs, line updates and next phase.
    always_comb begin
        ph_d     = ph_q;
        req_done = 1'b0;
        bus_req  = 1'b0;
        cmd      = BC_IDLE;
        own_we   = 1'b0;
        own_st   = cur_st;
        if (ph_q == PH_WAIT) begin
            if (bus_reply_in) begin
                req_done = 1'b1;
                own_we   = 1'b1;
                own_st   = (op == OP_STORE) ? LS_MOD : LS_SHD;
                ph_d     = PH_ARB;
            end
        end else if (req_valid) begin
            if (need == BC_IDLE) begin
                req_done = 1'b1;
                own_we   = (op == OP_EVICT) && (cur_st != LS_INV);
                own_st   = LS_INV;
            end else begin
                bus_req = 1'b1;
                if (bus_gnt) begin
                    cmd = need;
                    if (need == BC_INV) begin
                        req_done = 1'b1;
                        own_we   = 1'b1;
                        own_st   = LS_MOD;
                    end else if (need == BC_WB) begin
                        req_done = 1'b1;
                        own_we   = 1'b1;
                        own_st   = LS_INV;
                    end else begin
                        ph_d = PH_WAIT;
                    end
                end
            end
        end
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) ph_q <= PH_ARB;
        else        ph_q <= ph_d;
    end
endmodule

// File: rtl/msi_snoop_ctrl.sv
// Top of the per-cache MSI coherence controller. Splits addresses into
// index and tag, looks up both the processor and the snoop address, and
// joins the request sequencer and the snoop reaction onto one line store.
// Assumes: ADDR_W > IDX_W; the bus carries one command per cycle.
module msi_snoop_ctrl
    import msi_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int IDX_W  = 2,
    parameter int ID_W   = 2,
    parameter int MY_ID  = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_done,
    output logic              req_stall,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic [2:0]        bus_cmd,
    output logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_reply_in,
    input  logic [2:0]        snp_cmd,
    input  logic [ADDR_W-1:0] snp_addr,
    input  logic [ID_W-1:0]   snp_id,
    output logic              snp_reply
);
    localparam int TAG_W = ADDR_W - IDX_W;

    logic [IDX_W-1:0] r_idx, s_idx;
    logic [TAG_W-1:0] r_tag, s_tag, r_tag_q, s_tag_q;
    line_st_t         r_st_q, s_st_q, r_cur, s_cur;
    logic             own_we, snp_we;
    line_st_t         own_st, snp_st;
    bus_cmd_t         cmd;

    // Address split and tag-qualified states.
    always_comb begin
        r_idx = req_addr[IDX_W-1:0];
        r_tag = req_addr[ADDR_W-1:IDX_W];
        s_idx = snp_addr[IDX_W-1:0];
        s_tag = snp_addr[ADDR_W-1:IDX_W];
        r_cur = (r_tag_q == r_tag) ? r_st_q : LS_INV;
        s_cur = (s_tag_q == s_tag) ? s_st_q : LS_INV;
    end

    msi_line_array #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_lines (
        .clk     (clk),
        .rst_n   (rst_n),
        .rda_idx (r_idx),
        .rda_st  (r_st_q),
        .rda_tag (r_tag_q),
        .rdb_idx (s_idx),
        .rdb_st  (s_st_q),
        .rdb_tag (s_tag_q),
        .own_we  (own_we),
        .own_idx (r_idx),
        .own_tag (r_tag),
        .own_st  (own_st),
        .snp_we  (snp_we),
        .snp_idx (s_idx),
        .snp_st  (snp_st)
    );

    msi_req_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_op       (req_op),
        .cur_st       (r_cur),
        .bus_gnt      (bus_gnt),
        .bus_reply_in (bus_reply_in),
        .req_done     (req_done),
        .bus_req      (bus_req),
        .cmd          (cmd),
        .own_we       (own_we),
        .own_st       (own_st)
    );

    msi_snoop_unit #(.ID_W(ID_W), .MY_ID(MY_ID)) u_snoop (
        .snp_cmd (snp_cmd),
        .snp_id  (snp_id),
        .cur_st  (s_cur),
        .upd_we  (snp_we),
        .upd_st  (snp_st),
        .reply   (snp_reply)
    );

    // Drive the bus and the processor stall.
    always_comb begin
        bus_cmd   = 3'(cmd);
        bus_addr  = req_addr;
        req_stall = req_valid && !req_done;
    end
endmodule

// File: rtl/msi_snoop_ctrl_chk.sv
// Property checker for msi_snoop_ctrl, attached by bind below.
// Assumes: the same parameter values as the bound instance.
module msi_snoop_ctrl_chk #(
    parameter int ADDR_W = 8,
    parameter int ID_W   = 2,
    parameter int MY_ID  = 0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [ADDR_W-1:0] req_addr,
    input logic              req_done,
    input logic              req_stall,
    input logic              bus_req,
    input logic              bus_gnt,
    input logic [2:0]        bus_cmd,
    input logic [2:0]        snp_cmd,
    input logic [ID_W-1:0]   snp_id,
    input logic              snp_reply
);
    // R1: nothing is owned right after reset, so no snoop can be answered.
    a_r1_no_reply_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> !snp_reply);

    // R2: a command leaves the block only in a granted cycle.
    a_r2_cmd_needs_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cmd != 3'd0) |-> bus_gnt);

    // R2: a stalled request is held steady by the processor.
    a_r2_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        req_stall |=> (req_valid && $stable(req_addr)));

    // R3: after issuing a read the block waits and does not request again.
    a_r3_wait_no_rerequest: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_cmd == 3'd1) || (bus_cmd == 3'd2)) |=> !bus_req);

    // R4: a dataless upgrade completes in its granted cycle.
    a_r4_upgrade_done: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cmd == 3'd3) |-> req_done);

    // R5: a write-back completes in its granted cycle.
    a_r5_writeback_done: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cmd == 3'd4) |-> req_done);

    // R9: a reply answers only a foreign read or exclusive read.
    a_r9_reply_foreign_read: assert property (@(posedge clk) disable iff (!rst_n)
        snp_reply |-> ((snp_id != ID_W'(MY_ID)) && ((snp_cmd == 3'd1) || (snp_cmd == 3'd2))));
endmodule

bind msi_snoop_ctrl msi_snoop_ctrl_chk #(
    .ADDR_W(ADDR_W), .ID_W(ID_W), .MY_ID(MY_ID)
) u_chk (.*);

// File: tb/msi_snoop_ctrl_test.sv
// Sweeps every start state against every request and every snoop for the
// MSI controller, acting as bus arbiter and memory.
module msi_snoop_ctrl_test;
    localparam int AW = 8;
    localparam int IW = 2;
    localparam logic [1:0] OTHER = 2'd1;
    localparam logic [1:0] SELF  = 2'd0;
    localparam logic [AW-1:0] A0 = 8'h10;
    localparam logic [AW-1:0] A1 = 8'h11;
    localparam logic [AW-1:0] A1X = 8'h21;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [1:0] req_op = 2'd0;
    logic [AW-1:0] req_addr = '0;
    logic req_done, req_stall, bus_req, snp_reply;
    logic bus_gnt = 1'b0;
    logic [2:0] bus_cmd;
    logic [AW-1:0] bus_addr;
    logic bus_reply_in = 1'b0;
    logic [2:0] snp_cmd = 3'd0;
    logic [AW-1:0] snp_addr = '0;
    logic [1:0] snp_id = 2'd0;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    msi_snoop_ctrl #(.ADDR_W(AW), .IDX_W(IW), .ID_W(2), .MY_ID(0)) uut (.*);

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Processor request; bench grants one cycle after the request and
    // replies one cycle after a read command.
    task automatic do_req(input logic [1:0] op, input logic [AW-1:0] a,
                          output logic [2:0] cmd, output bit local_done);
        bit pending = 1'b0;
        cmd = 3'd0;
        local_done = 1'b0;
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = a;
        #1;
        if (req_done) local_done = 1'b1;
        else begin
            for (int i = 0; i < 20; i++) begin
                @(negedge clk);
                bus_gnt = bus_req;
                bus_reply_in = pending;
                #1;
                if (bus_cmd != 3'd0) begin
                    cmd = bus_cmd;
                    pending = (bus_cmd == 3'd1) || (bus_cmd == 3'd2);
                end
                if (req_done) break;
            end
        end
        @(posedge clk); #1;
        req_valid = 1'b0; bus_gnt = 1'b0; bus_reply_in = 1'b0;
    endtask

    task automatic do_snoop(input logic [2:0] c, input logic [AW-1:0] a,
                            input logic [1:0] id, output bit rep);
        @(negedge clk);
        snp_cmd = c; snp_addr = a; snp_id = id;
        #1 rep = snp_reply;
        @(posedge clk); #1;
        snp_cmd = 3'd0;
    endtask

    // Read a line state back through the ports and restore it.
    task automatic probe(input logic [AW-1:0] a, output int st);
        bit rep, loc;
        logic [2:0] c;
        do_snoop(3'd1, a, OTHER, rep);
        if (rep) begin
            st = 2;
            do_req(2'd1, a, c, loc);
        end else begin
            do_req(2'd0, a, c, loc);
            if (loc) st = 1;
            else begin
                st = 0;
                do_req(2'd2, a, c, loc);
            end
        end
    endtask

    task automatic set_state(input logic [AW-1:0] a, input int st);
        logic [2:0] c;
        bit loc;
        do_req(2'd2, a, c, loc);
        if (st == 1) do_req(2'd0, a, c, loc);
        if (st == 2) do_req(2'd1, a, c, loc);
    endtask

    // Expected command for request op on state s (0 I, 1 S, 2 M).
    function automatic int exp_cmd(input int op, input int s);
        if (op == 0) return (s == 0) ? 1 : 0;
        if (op == 1) return (s == 0) ? 2 : (s == 1) ? 3 : 0;
        return (s == 2) ? 4 : 0;
    endfunction

    function automatic int exp_next(input int op, input int s);
        if (op == 0) return (s == 0) ? 1 : s;
        if (op == 1) return 2;
        return 0;
    endfunction

    function automatic string req_tag(input int op, input int s);
        if (exp_cmd(op, s) == 0) return (op == 2 && s == 1) ? "R5" : "R6";
        if (op == 0) return "R2";
        if (op == 1) return (s == 0) ? "R3" : "R4";
        return "R5";
    endfunction

    initial begin
        logic [2:0] c;
        bit loc, rep;
        int st, es, er;
        string tg;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(!bus_req && !req_done && !snp_reply, "R1 idle outputs", int'(bus_req), 0);
        do_snoop(3'd1, A0, OTHER, rep);
        check(!rep, "R1 no reply after reset", int'(rep), 0);
        probe(A0, st);
        check(st == 0, "R1 line invalid after reset", st, 0);

        // Every start state against every processor request.
        for (int s = 0; s < 3; s++) begin
            for (int op = 0; op < 3; op++) begin
                set_state(A0, s);
                do_req(2'(op), A0, c, loc);
                tg = req_tag(op, s);
                check(int'(c) == exp_cmd(op, s), {tg, " command"}, int'(c), exp_cmd(op, s));
                check(loc == (exp_cmd(op, s) == 0), {tg, " local completion"}, int'(loc),
                      int'(exp_cmd(op, s) == 0));
                probe(A0, st);
                check(st == exp_next(op, s), {tg, " next state"}, st, exp_next(op, s));
            end
        end

        // Every start state against every snoop, from another id and own id.
        for (int s = 0; s < 3; s++) begin
            for (int sc = 1; sc < 5; sc++) begin
                for (int who = 0; who < 2; who++) begin
                    set_state(A0, s);
                    do_snoop(3'(sc), A0, (who == 1) ? OTHER : SELF, rep);
                    es = s; er = 0;
                    if (who == 1) begin
                        if (sc == 1 && s == 2) begin es = 1; er = 1; end
                        if (sc == 2 && s != 0) begin es = 0; er = (s == 2) ? 1 : 0; end
                        if (sc == 3 && s == 1) es = 0;
                    end
                    tg = (who == 0) ? "R9" : (sc == 1) ? "R7" : "R8";
                    check(int'(rep) == er, {tg, " snoop reply"}, int'(rep), er);
                    probe(A0, st);
                    check(st == es, {tg, " state after snoop"}, st, es);
                end
            end
        end

        // R10: upgrade waiting for grant loses its copy, issues exclusive read.
        set_state(A0, 1);
        @(negedge clk);
        req_valid = 1'b1; req_op = 2'd1; req_addr = A0;
        snp_cmd = 3'd3; snp_addr = A0; snp_id = OTHER;
        #1 check(req_stall && bus_req, "R10 stall while ungranted", int'(req_stall), 1);
        @(negedge clk);
        snp_cmd = 3'd0; bus_gnt = 1'b1;
        #1 check(bus_cmd == 3'd2, "R10 command rechosen at grant", int'(bus_cmd), 2);
        @(negedge clk);
        bus_gnt = 1'b0; bus_reply_in = 1'b1;
        #1 check(req_done, "R10 done on reply", int'(req_done), 1);
        @(posedge clk); #1 req_valid = 1'b0; bus_reply_in = 1'b0;
        probe(A0, st);
        check(st == 2, "R10 modified after rechosen read", st, 2);

        // R10: evict waiting on Modified is downgraded by a snoop, then silent.
        set_state(A0, 2);
        @(negedge clk);
        req_valid = 1'b1; req_op = 2'd2; req_addr = A0;
        snp_cmd = 3'd1; snp_addr = A0; snp_id = OTHER;
        #1 check(snp_reply && bus_req, "R10 snoop served while waiting", int'(snp_reply), 1);
        @(negedge clk);
        snp_cmd = 3'd0;
        #1 check(req_done && !bus_req && bus_cmd == 3'd0, "R10 evict silent after downgrade",
                 int'(req_done), 1);
        @(posedge clk); #1 req_valid = 1'b0;
        probe(A0, st);
        check(st == 0, "R10 invalid after evict", st, 0);

        // R11: tag mismatch on the same index.
        set_state(A1, 1);
        do_req(2'd2, A1X, c, loc);
        check(loc && c == 3'd0, "R11 evict of other tag is local", int'(c), 0);
        probe(A1, st);
        check(st == 1, "R11 resident line untouched", st, 1);
        do_req(2'd0, A1X, c, loc);
        check(c == 3'd1, "R11 other tag reads as invalid", int'(c), 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        finished = 1'b1;
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule